// File: doc/BRIEF.md
# Timed ADC Sampling Host Controller

This block sits on the host side of a 16-bit parallel successive-approximation converter that is controlled by a read/convert strobe, an active-low chip select and a busy flag. A free-running sample timer, enabled by `enable` and spaced by `period` clock cycles, asks for a new sample. On each accepted request the controller lowers read/convert, holds it for a fixed setup count, lowers chip select for a fixed pulse count to start the conversion, and then releases both strobes while it watches for the busy flag to rise again.

Once busy rises, the controller reads the result with read/convert high and chip select low. In word mode it takes all 16 bits in one access. In byte mode it makes two accesses on the low eight data lines, first with byte select low and then with byte select high, and joins the halves. The finished two's complement word appears on `smp_data` with a one-cycle `smp_valid` and a one-cycle `done_irq`. Timer requests that arrive while a cycle is already running are dropped and recorded in a sticky overrun flag. A converter that never raises busy is caught by a programmable timeout that abandons the cycle and sets a sticky error flag.

The controller is a single state machine with the states IDLE, SETUP, PULSE, WAIT, RD_A, GAP, RD_B and DONE. Its transitions are: IDLE to SETUP on a timer tick; SETUP to PULSE after `SETUP_CYC` cycles; PULSE to WAIT after `PULSE_CYC` cycles; WAIT to RD_A on a synchronised busy rising edge; WAIT to IDLE on timeout; RD_A to GAP (byte mode) or to DONE (word mode) after `RD_CYC` cycles; GAP to RD_B after one cycle; RD_B to DONE after `RD_CYC` cycles; and DONE to IDLE after one cycle.

Top module: `adc_sample_host`

## Requirements
- R1: While reset is asserted and right after it, `adc_rc_n` = 1, `adc_cs_n` = 1, `adc_byte_sel` = 0, `smp_valid` = 0, `done_irq` = 0, `overrun` = 0 and `timeout_err` = 0.
- R2: With `enable` high, the timer produces a tick every `period` cycles. A tick that finds the controller idle starts a cycle, so successive conversion starts are exactly `period` cycles apart.
- R3: A conversion start holds `adc_rc_n` low with `adc_cs_n` high for exactly `SETUP_CYC` cycles before `adc_cs_n` falls.
- R4: Both strobes then stay low together for exactly `PULSE_CYC` cycles and rise in the same cycle.
- R5: No read access (`adc_cs_n` low with `adc_rc_n` high) begins until busy has been seen to rise after the start pulse.
- R6: In word mode there is one read access of `RD_CYC` cycles with `adc_byte_sel` = 0. The word is taken from `adc_data[15:0]` in its last cycle.
- R7: In byte mode the first access (`adc_byte_sel` = 0) takes `adc_data[7:0]` as the low byte. Chip select is then high for one cycle. The second access (`adc_byte_sel` = 1) takes `adc_data[7:0]` as the high byte, and the result is {high, low}. `adc_byte_sel` is high for exactly `RD_CYC`+1 cycles per byte-mode cycle. `byte_mode` is sampled when a cycle starts.
- R8: Each completed conversion gives exactly one cycle of `smp_valid` with the assembled word on `smp_data`, and `done_irq` is high in that same cycle only.
- R9: A tick that arrives while a cycle is running is dropped (no extra cycle starts) and sets the sticky `overrun` flag, which stays set until reset.
- R10: If no busy rising edge is seen within `timeout_lim` cycles of the strobes rising after the start pulse, the controller returns to idle without a `smp_valid` and sets the sticky `timeout_err` exactly `timeout_lim` cycles after that rise.
- R11: With `enable` low the timer is held cleared and no conversion is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the sample timer |
| period | input | PERIOD_W | Tick spacing in clock cycles |
| byte_mode | input | 1 | 1 = two 8-bit reads, 0 = one 16-bit read |
| timeout_lim | input | TO_W | Cycles allowed in WAIT for busy to rise |
| adc_rc_n | output | 1 | Read/convert strobe, low = convert |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_byte_sel | output | 1 | Byte select, 1 = high byte on the low lane |
| adc_busy | input | 1 | Converter busy flag, low while converting |
| adc_data | input | DATA_W | Converter data bus |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | DATA_W | Assembled two's complement sample |
| done_irq | output | 1 | One-cycle completion interrupt |
| overrun | output | 1 | Sticky: tick dropped while busy |
| timeout_err | output | 1 | Sticky: busy never rose |

## Verification
The bench builds the controller with `SETUP_CYC`=2, `PULSE_CYC`=5 and `RD_CYC`=3, against a converter model that takes 40 cycles per conversion. These small counts let exact strobe widths and tick spacing be measured within a few hundred cycles. A `period` of 100 keeps every cycle inside one tick, while a `period` of 30 is shorter than a word-mode cycle and so forces dropped ticks and the overrun flag. A `timeout_lim` of 50 against a model that ignores the start pulse brings the abort path and its exact timing within reach. Sample words include 0x8000, 0x7FFF and 0xFFFF so that a swapped or misplaced byte shows in the data.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_WAIT,
        ST_RD_A,
        ST_GAP,
        ST_RD_B,
        ST_DONE
    } host_state_t;
endpackage

// File: rtl/smp_tick_gen.sv
module smp_tick_gen #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    localparam int EXT_W = PERIOD_W + 1;

    logic [PERIOD_W-1:0] cnt;
    logic [EXT_W-1:0]    cnt_inc;
    logic                wrap;

    assign cnt_inc = {1'b0, cnt} + EXT_W'(1);
    assign wrap    = (cnt_inc >= {1'b0, period});
    assign tick    = en && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !en || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[PERIOD_W-1:0];
        end
    end
endmodule

// File: rtl/busy_rise_det.sv
module busy_rise_det #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    output logic rise
);
    logic [SYNC_N:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[SYNC_N-1:0], busy_in};
        end
    end

    assign rise = sh[SYNC_N-1] & ~sh[SYNC_N];
endmodule

// File: rtl/adc_sample_host.sv
module adc_sample_host
    import adc_host_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PERIOD_W  = 16,
    parameter int TO_W      = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 5,
    parameter int RD_CYC    = 3,
    parameter int SYNC_N    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                byte_mode,
    input  logic [TO_W-1:0]     timeout_lim,
    output logic                adc_rc_n,
    output logic                adc_cs_n,
    output logic                adc_byte_sel,
    input  logic                adc_busy,
    input  logic [DATA_W-1:0]   adc_data,
    output logic                smp_valid,
    output logic [DATA_W-1:0]   smp_data,
    output logic                done_irq,
    output logic                overrun,
    output logic                timeout_err
);
    localparam int HALF_W     = DATA_W / 2;
    localparam int STROBE_MAX = (SETUP_CYC > PULSE_CYC) ?
                                ((SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC) :
                                ((PULSE_CYC > RD_CYC) ? PULSE_CYC : RD_CYC);
    localparam int STROBE_W   = $clog2(STROBE_MAX + 1);
    localparam int PH_W       = (TO_W > STROBE_W) ? TO_W : STROBE_W;
    localparam logic [PH_W:0] SETUP_L = (PH_W+1)'(SETUP_CYC);
    localparam logic [PH_W:0] PULSE_L = (PH_W+1)'(PULSE_CYC);
    localparam logic [PH_W:0] RD_L    = (PH_W+1)'(RD_CYC);

    host_state_t        st, st_n;
    logic [PH_W-1:0]    ph;
    logic [PH_W:0]      ph_nxt;
    logic [PH_W:0]      to_ext;
    logic               tick;
    logic               busy_rise;
    logic               mode_q;
    logic [HALF_W-1:0]  lo_q;
    logic [DATA_W-1:0]  word_q;

    smp_tick_gen #(.PERIOD_W(PERIOD_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (enable),
        .period(period),
        .tick  (tick)
    );

    busy_rise_det #(.SYNC_N(SYNC_N)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_in(adc_busy),
        .rise   (busy_rise)
    );

    assign ph_nxt = {1'b0, ph} + (PH_W+1)'(1);
    assign to_ext = (PH_W+1)'(timeout_lim);

    // next-state selection
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (tick) st_n = ST_SETUP;
            ST_SETUP: if (ph_nxt == SETUP_L) st_n = ST_PULSE;
            ST_PULSE: if (ph_nxt == PULSE_L) st_n = ST_WAIT;
            ST_WAIT: begin
                if (busy_rise)            st_n = ST_RD_A;
                else if (ph_nxt >= to_ext) st_n = ST_IDLE;
            end
            ST_RD_A:  if (ph_nxt == RD_L) st_n = mode_q ? ST_GAP : ST_DONE;
            ST_GAP:   st_n = ST_RD_B;
            ST_RD_B:  if (ph_nxt == RD_L) st_n = ST_DONE;
            ST_DONE:  st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register, phase counter, captures and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            ph          <= '0;
            mode_q      <= 1'b0;
            lo_q        <= '0;
            word_q      <= '0;
            overrun     <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            st <= st_n;
            ph <= (st_n != st) ? '0 : ph_nxt[PH_W-1:0];
            if (st == ST_IDLE && tick) mode_q <= byte_mode;
            if (st == ST_RD_A && st_n != ST_RD_A) begin
                if (mode_q) lo_q   <= adc_data[HALF_W-1:0];
                else        word_q <= adc_data;
            end
            if (st == ST_RD_B && st_n == ST_DONE)
                word_q <= {adc_data[HALF_W-1:0], lo_q};
            if (tick && st != ST_IDLE) overrun <= 1'b1;
            if (st == ST_WAIT && st_n == ST_IDLE) timeout_err <= 1'b1;
        end
    end

    // strobes and result outputs decoded from the state
    always_comb begin
        adc_rc_n     = 1'b1;
        adc_cs_n     = 1'b1;
        adc_byte_sel = 1'b0;
        smp_valid    = 1'b0;
        done_irq     = 1'b0;
        unique case (st)
            ST_SETUP: adc_rc_n = 1'b0;
            ST_PULSE: begin adc_rc_n = 1'b0; adc_cs_n = 1'b0; end
            ST_RD_A:  adc_cs_n = 1'b0;
            ST_GAP:   adc_byte_sel = 1'b1;
            ST_RD_B:  begin adc_cs_n = 1'b0; adc_byte_sel = 1'b1; end
            ST_DONE:  begin smp_valid = 1'b1; done_irq = 1'b1; end
            default: ;
        endcase
    end

    assign smp_data = word_q;

    AST_SETUP_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n) && !adc_rc_n) |-> $past(!adc_rc_n)); // R3
    AST_PULSE_ENDS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_cs_n) && $past(!adc_rc_n)) |-> adc_rc_n); // R4
    AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && adc_rc_n && !$past(!adc_cs_n && adc_rc_n))
            |-> $past(st == ST_WAIT || st == ST_GAP)); // R5
    AST_WORD_MODE_NO_BSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !adc_byte_sel); // R6
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R9
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err); // R10
endmodule

// File: tb/adc_sample_host_bench.sv
module adc_sample_host_bench;
    localparam int CLK_NS = 10;
    localparam int SETUP  = 2;
    localparam int PULSE  = 5;
    localparam int RD     = 3;
    localparam int CONV   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        byte_mode = 1'b0;
    logic [15:0] period = 16'd100;
    logic [15:0] tlim = 16'd200;
    logic        adc_rc_n, adc_cs_n, adc_byte_sel, smp_valid, done_irq, overrun, timeout_err;
    logic [15:0] adc_data, smp_data;
    logic        busy_m = 1'b1;

    adc_sample_host #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .RD_CYC(RD)) u_adc_sample_host (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period), .byte_mode(byte_mode),
        .timeout_lim(tlim), .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n), .adc_byte_sel(adc_byte_sel),
        .adc_busy(busy_m), .adc_data(adc_data), .smp_valid(smp_valid), .smp_data(smp_data),
        .done_irq(done_irq), .overrun(overrun), .timeout_err(timeout_err)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // converter model
    logic [15:0] out_q = 16'h0;
    logic        cs_prev = 1'b1;
    int          conv_left = 0;
    int          sample_idx = 0;
    bit          dead = 1'b0;
    logic [15:0] exp_q[$];

    function automatic logic [15:0] gen_word(int i);
        case (i % 5)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            default: return 16'(i * 40503 + 12345);
        endcase
    endfunction

    always @(posedge clk) begin
        cs_prev <= adc_cs_n;
        if (!rst_n) begin
            busy_m    <= 1'b1;
            conv_left <= 0;
        end else if (cs_prev && !adc_cs_n && !adc_rc_n && conv_left == 0) begin
            if (!dead) begin
                busy_m    <= 1'b0;
                conv_left <= CONV;
            end
        end else if (conv_left == 1) begin
            conv_left <= 0;
            busy_m    <= 1'b1;
            out_q     <= gen_word(sample_idx);
            exp_q.push_back(gen_word(sample_idx));
            sample_idx <= sample_idx + 1;
        end else if (conv_left > 1) begin
            conv_left <= conv_left - 1;
        end
    end

    assign adc_data = (!adc_cs_n && adc_rc_n) ?
                      (adc_byte_sel ? {out_q[7:0], out_q[15:8]} : out_q) : 16'h0000;

    // per-cycle monitor
    int cyc = 0, starts = 0, last_start = -1, start_gap = 0;
    int rc_run = 0, pulse_run = 0, bsel_run = 0, valids = 0;
    int pulse_end_cyc = 0, to_gap = -1;
    bit rd_while_busy = 1'b0, err_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!adc_rc_n && adc_cs_n) rc_run++;
            if (!adc_rc_n && !adc_cs_n) begin
                if (pulse_run == 0) begin
                    chk(rc_run == SETUP, "R3", "setup cycles", rc_run, SETUP);
                    starts++;
                    if (last_start >= 0) start_gap = cyc - last_start;
                    last_start = cyc;
                end
                pulse_run++;
            end
            if (adc_rc_n && pulse_run != 0) begin
                chk(pulse_run == PULSE && adc_cs_n, "R4", "pulse cycles", pulse_run, PULSE);
                pulse_run = 0;
                rc_run = 0;
                pulse_end_cyc = cyc;
            end
            if (!adc_cs_n && adc_rc_n && !busy_m) rd_while_busy = 1'b1;
            if (adc_byte_sel) bsel_run++;
            if (timeout_err && !err_prev) to_gap = cyc - pulse_end_cyc;
            err_prev = timeout_err;
            if (done_irq != smp_valid) chk(0, "R8", "irq vs valid", done_irq, smp_valid);
            if (smp_valid) begin
                valids++;
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "valid with no conversion", valids, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(smp_data == e, byte_mode ? "R7" : "R6", "sample word", smp_data, e);
                end
                chk(bsel_run == (byte_mode ? RD + 1 : 0), "R7", "byte select cycles",
                    bsel_run, byte_mode ? RD + 1 : 0);
                chk(!rd_while_busy, "R5", "read before busy rise", rd_while_busy, 0);
                bsel_run = 0;
                rd_while_busy = 1'b0;
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_fail++;
            $display("FAIL R8 watchdog expired: got %0d cycles expected fewer", wd);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_valids(int n, int max_cyc, string tag);
        int target;
        int t;
        target = valids + n;
        t = 0;
        while (valids < target && t < max_cyc) begin
            @(negedge clk); #1;
            t++;
        end
        chk(valids >= target, tag, "samples delivered", valids, target);
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        int s;
        int v;
        int t;
        idle_cycles(4);
        // R1 reset state
        chk(adc_rc_n == 1, "R1", "rc_n in reset", adc_rc_n, 1);
        chk(adc_cs_n == 1, "R1", "cs_n in reset", adc_cs_n, 1);
        chk(adc_byte_sel == 0, "R1", "byte_sel in reset", adc_byte_sel, 0);
        chk(smp_valid == 0, "R1", "valid in reset", smp_valid, 0);
        chk(done_irq == 0, "R1", "irq in reset", done_irq, 0);
        chk(overrun == 0, "R1", "overrun in reset", overrun, 0);
        chk(timeout_err == 0, "R1", "timeout in reset", timeout_err, 0);
        rst_n = 1'b1;
        idle_cycles(3);
        chk(adc_cs_n == 1 && adc_rc_n == 1, "R1", "strobes after reset", adc_cs_n, 1);

        // word mode
        enable = 1'b1;
        wait_valids(4, 2000, "R6");
        chk(start_gap == 100, "R2", "start spacing", start_gap, 100);
        chk(overrun == 0, "R9", "no overrun at long period", overrun, 0);
        chk(timeout_err == 0, "R10", "no timeout in normal run", timeout_err, 0);

        // byte mode
        enable = 1'b0;
        idle_cycles(150);
        byte_mode = 1'b1;
        enable = 1'b1;
        wait_valids(4, 2000, "R7");
        chk(start_gap == 100, "R2", "start spacing byte mode", start_gap, 100);

        // enable low
        enable = 1'b0;
        idle_cycles(100);
        s = starts;
        v = valids;
        idle_cycles(300);
        chk(starts == s, "R11", "starts while disabled", starts, s);
        chk(valids == v, "R11", "samples while disabled", valids, v);

        // overrun
        byte_mode = 1'b0;
        period = 16'd30;
        chk(overrun == 0, "R9", "overrun before short period", overrun, 0);
        enable = 1'b1;
        wait_valids(3, 2000, "R9");
        chk(overrun == 1, "R9", "overrun after dropped ticks", overrun, 1);
        chk(start_gap > 30, "R9", "dropped tick spacing", start_gap, 60);
        enable = 1'b0;
        idle_cycles(100);

        // timeout
        period = 16'd200;
        tlim = 16'd50;
        dead = 1'b1;
        s = starts;
        v = valids;
        enable = 1'b1;
        t = 0;
        while (starts == s && t < 400) begin idle_cycles(1); t++; end
        t = 0;
        while (!timeout_err && t < 300) begin idle_cycles(1); t++; end
        chk(timeout_err == 1, "R10", "timeout flag", timeout_err, 1);
        chk(to_gap == 50, "R10", "timeout cycles", to_gap, 50);
        chk(valids == v, "R10", "no sample on timeout", valids, v);
        chk(adc_cs_n == 1 && adc_rc_n == 1, "R10", "strobes idle after abort", adc_cs_n, 1);
        dead = 1'b0;
        wait_valids(1, 600, "R10");
        enable = 1'b0;
        idle_cycles(20);
        chk(exp_q.size() == 0, "R8", "unreported conversions", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule